// File: doc/BRIEF.md
# Modem Line Status and Loopback Unit

This unit holds the modem-control and modem-status state of a 16550-style serial port. A register write sets the control byte, whose low five bits drive four handshake output pins and a loopback switch. Four synchronised handshake inputs (clear-to-send, data-set-ready, carrier-detect and ring) are sampled every cycle into the high nibble of a status byte. The low nibble of that byte records which lines have changed since the status was last read. Any recorded change raises a modem interrupt request, and a status read strobe clears the record.

In loopback mode the control bits are fed back in place of the external inputs through a fixed crossover. The external outputs are then held inactive (low), so the unit can be self-tested with no activity on the external lines. The interrupt prioritiser and the input synchronisers are outside the block.

Two small state machines govern the block. The line tracker has states `TRK_PRIME` and `TRK_RUN`. `TRK_PRIME` is entered at reset. On the first clock after reset it captures the selected lines without recording any change, then moves to `TRK_RUN` (transition *prime_done*). It stays in `TRK_RUN` until the next reset. The line-source selector has states `MODE_PINS` and `MODE_LOOP`, which follow the loopback control bit. Transition *loop_on* happens when a write sets bit 4, and *loop_off* when a write clears it.

Top module: `modem_line_unit`

## Requirements
- R1: At reset the control byte reads 0x08 (OUT2 set), the status byte reads 0x00, `modem_irq` is low and, of the output pins, only `out2_out` is high.
- R2: A control write stores bits [4:0] of the write data (bit 4 loop, 3 OUT2, 2 OUT1, 1 RTS, 0 DTR) and updates the control byte after the write edge; bits above 4 read back as zero.
- R3: Outside loopback, `dtr_out`, `rts_out`, `out1_out` and `out2_out` equal control bits 0, 1, 2 and 3.
- R4: Status bits 7, 6, 5 and 4 show carrier-detect, ring, data-set-ready and clear-to-send one clock after the selected line value is presented. The first clock after reset loads these bits without recording any change.
- R5: When carrier-detect, data-set-ready or clear-to-send differs from its previous sampled value, status bit 3, 1 or 0 respectively is set.
- R6: Status bit 2 (ring trailing edge) is set only when the ring line goes from 1 to 0, never on a 0-to-1 change.
- R7: A set change bit stays set until a status read, even when the line returns to its earlier value.
- R8: A status read strobe clears all four change bits at that edge. A change detected at the same edge still sets its bit.
- R9: `modem_irq` is high exactly when at least one of status bits 3..0 is set.
- R10: In loopback, OUT2 is seen as carrier-detect, OUT1 as ring, RTS as clear-to-send and DTR as data-set-ready. These values take effect one clock after the control byte changes, and changes they cause are recorded like external ones.
- R11: In loopback, all four output pins are driven low and the external input pins have no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | BUS_W | Control write data |
| ctl_rd_data | output | BUS_W | Current control byte, zero-extended |
| stat_rd_en | input | 1 | Status read strobe; clears change bits |
| stat_rd_data | output | BUS_W | Status byte: lines in [7:4], change bits in [3:0] |
| cts_in | input | 1 | Clear-to-send input (synchronised) |
| dsr_in | input | 1 | Data-set-ready input (synchronised) |
| dcd_in | input | 1 | Carrier-detect input (synchronised) |
| ri_in | input | 1 | Ring input (synchronised) |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| modem_irq | output | 1 | Modem interrupt request |

## Verification
The bench builds the block with the default bus width of 8, so the status and control bytes fill the whole data path and the zero upper control bits are visible on read. With this width, each change bit can be lined up against its own line bit in one byte. This covers a ring rise against a ring fall, a read that coincides with a new change, and the loopback crossover in both directions through `loop_on` and `loop_off`.

// File: rtl/msu_pkg.sv
package msu_pkg;
    localparam int LINE_W = 4;
    localparam int CTL_W  = 5;
    localparam int STAT_W = 2 * LINE_W;

    // line nibble positions (also change-bit positions)
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;

    typedef enum logic {TRK_PRIME, TRK_RUN} trk_state_e;
    typedef enum logic {MODE_PINS, MODE_LOOP} mode_e;
endpackage

// File: rtl/msu_ctl_reg.sv
module msu_ctl_reg
    import msu_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [CTL_W-1:0]  ctl_q,
    output mode_e             mode,
    output logic [CTL_W-2:0]  pins_o
);
    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = wr_data[CTL_W-1:0];
    end

    // state register: the loop bit selects the mode state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    always_comb mode = ctl_q[CB_LOOP] ? MODE_LOOP : MODE_PINS;

    // outputs: pins gated by mode
    for (genvar i = 0; i < CTL_W - 1; i++) begin : g_pin
        always_comb begin
            unique case (mode)
                MODE_PINS: pins_o[i] = ctl_q[i];
                MODE_LOOP: pins_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/msu_line_sel.sv
module msu_line_sel
    import msu_pkg::*;
(
    input  mode_e              mode,
    input  logic [CTL_W-1:0]   ctl_q,
    input  logic [LINE_W-1:0]  ext_lines,
    output logic [LINE_W-1:0]  line_sel
);
    logic [LINE_W-1:0] loop_lines;

    always_comb begin
        loop_lines          = '0;
        loop_lines[LN_DCD]  = ctl_q[CB_OUT2];
        loop_lines[LN_RI]   = ctl_q[CB_OUT1];
        loop_lines[LN_DSR]  = ctl_q[CB_DTR];
        loop_lines[LN_CTS]  = ctl_q[CB_RTS];
    end

    always_comb begin
        unique case (mode)
            MODE_PINS: line_sel = ext_lines;
            MODE_LOOP: line_sel = loop_lines;
        endcase
    end
endmodule

// File: rtl/msu_delta_trk.sv
module msu_delta_trk
    import msu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  line_sel,
    input  logic               rd_clr,
    output logic [LINE_W-1:0]  line_q,
    output logic [LINE_W-1:0]  delta_q
);
    trk_state_e        state_q, state_d;
    logic [LINE_W-1:0] raise;
    logic [LINE_W-1:0] delta_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_PRIME;
            line_q  <= '0;
            delta_q <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_sel;
            delta_q <= delta_d;
        end
    end

    always_comb begin
        raise        = line_q ^ line_sel;
        raise[LN_RI] = line_q[LN_RI] & ~line_sel[LN_RI];
    end

    always_comb begin
        state_d = state_q;
        delta_d = rd_clr ? '0 : delta_q;
        unique case (state_q)
            TRK_PRIME: state_d = TRK_RUN;
            TRK_RUN:   delta_d = delta_d | raise;
        endcase
    end
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
    import msu_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [BUS_W-1:0]  ctl_wr_data,
    output logic [BUS_W-1:0]  ctl_rd_data,
    input  logic              stat_rd_en,
    output logic [BUS_W-1:0]  stat_rd_data,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              dcd_in,
    input  logic              ri_in,
    output logic              rts_out,
    output logic              dtr_out,
    output logic              out1_out,
    output logic              out2_out,
    output logic              modem_irq
);
    logic [CTL_W-1:0]  ctl_q;
    mode_e             mode;
    logic [CTL_W-2:0]  pins;
    logic [LINE_W-1:0] ext_lines, line_sel, line_q, delta_q;

    always_comb begin
        ext_lines         = '0;
        ext_lines[LN_CTS] = cts_in;
        ext_lines[LN_DSR] = dsr_in;
        ext_lines[LN_RI]  = ri_in;
        ext_lines[LN_DCD] = dcd_in;
    end

    msu_ctl_reg #(.BUS_W(BUS_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .ctl_q(ctl_q), .mode(mode), .pins_o(pins)
    );

    msu_line_sel u_sel (
        .mode(mode), .ctl_q(ctl_q), .ext_lines(ext_lines), .line_sel(line_sel)
    );

    msu_delta_trk u_trk (
        .clk(clk), .rst_n(rst_n), .line_sel(line_sel), .rd_clr(stat_rd_en),
        .line_q(line_q), .delta_q(delta_q)
    );

    assign dtr_out      = pins[CB_DTR];
    assign rts_out      = pins[CB_RTS];
    assign out1_out     = pins[CB_OUT1];
    assign out2_out     = pins[CB_OUT2];
    assign ctl_rd_data  = BUS_W'(ctl_q);
    assign stat_rd_data = BUS_W'({line_q, delta_q});
    assign modem_irq    = |delta_q;
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr_en,
    input logic [BUS_W-1:0] ctl_wr_data,
    input logic [BUS_W-1:0] ctl_rd_data,
    input logic             stat_rd_en,
    input logic [BUS_W-1:0] stat_rd_data,
    input logic             rts_out,
    input logic             dtr_out,
    input logic             out1_out,
    input logic             out2_out,
    input logic             modem_irq
);
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> ctl_rd_data[4:0] == $past(ctl_wr_data[4:0])); // R2

    AST_LOOP_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[4] |-> !(rts_out || dtr_out || out1_out || out2_out)); // R11

    AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rd_data[2]) |-> ($past(stat_rd_data[6]) && !stat_rd_data[6])); // R6

    AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd_en |=> ((stat_rd_data[3:0] & $past(stat_rd_data[3:0])) == $past(stat_rd_data[3:0]))); // R7

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_en |=> (stat_rd_data[3:0] == 4'b0) || (stat_rd_data[7:4] != $past(stat_rd_data[7:4]))); // R8

    AST_IRQ_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        modem_irq == (stat_rd_data[3:0] != 4'b0)); // R9
endmodule

bind modem_line_unit msu_checker #(.BUS_W(BUS_W)) u_msu_checker (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data),
    .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out),
    .modem_irq(modem_irq)
);

// File: tb/modem_line_unit_bench.sv
module modem_line_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr_en = 1'b0;
    logic [BUS_W-1:0] ctl_wr_data = '0;
    logic [BUS_W-1:0] ctl_rd_data;
    logic stat_rd_en = 1'b0;
    logic [BUS_W-1:0] stat_rd_data;
    logic cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0, ri_in = 1'b0;
    logic rts_out, dtr_out, out1_out, out2_out, modem_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic [7:0] ctl;
        logic [3:0] po;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_line_unit #(.BUS_W(BUS_W)) u_modem_line_unit (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data),
        .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
        .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out),
        .modem_irq(modem_irq)
    );

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [3:0] po;
            e  = sb.pop_front();
            po = {out2_out, out1_out, rts_out, dtr_out};
            n_checks++;
            if (stat_rd_data !== e.st || ctl_rd_data !== e.ctl || po !== e.po || modem_irq !== e.irq) begin
                n_fails++;
                $display("FAIL %s actual st=%h ctl=%h pins=%b irq=%b expected st=%h ctl=%h pins=%b irq=%b",
                         e.tag, stat_rd_data, ctl_rd_data, po, modem_irq, e.st, e.ctl, e.po, e.irq);
            end
        end
    end

    // driver: apply lines {dcd,ri,dsr,cts}, strobes, then queue expectation after the edge
    task automatic cyc(input logic [3:0] ln, input logic wr, input logic [7:0] wd, input logic rd,
                       input logic [7:0] est, input logic [7:0] ectl, input logic [3:0] epo,
                       input logic eirq, input string tag);
        exp_t e;
        @(negedge clk);
        {dcd_in, ri_in, dsr_in, cts_in} = ln;
        ctl_wr_en   = wr;
        ctl_wr_data = wd;
        stat_rd_en  = rd;
        @(posedge clk);
        e.st = est; e.ctl = ectl; e.po = epo; e.irq = eirq; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        exp_t e;
        {dcd_in, ri_in, dsr_in, cts_in} = 4'b1011;
        repeat (3) @(posedge clk);
        e.st = 8'h00; e.ctl = 8'h08; e.po = 4'b1000; e.irq = 1'b0; e.tag = "R1 reset";
        sb.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
        //        lines   wr  wdata  rd  status ctl    pins     irq
        cyc(4'b1011, 0, 8'h00, 0, 8'hB0, 8'h08, 4'b1000, 0, "R4 prime no change");
        cyc(4'b1011, 0, 8'h00, 0, 8'hB0, 8'h08, 4'b1000, 0, "R4 steady lines");
        cyc(4'b1010, 0, 8'h00, 0, 8'hA1, 8'h08, 4'b1000, 1, "R5 R9 cts change");
        cyc(4'b1011, 0, 8'h00, 0, 8'hB1, 8'h08, 4'b1000, 1, "R7 sticky after return");
        cyc(4'b1011, 0, 8'h00, 1, 8'hB0, 8'h08, 4'b1000, 0, "R8 read clears");
        cyc(4'b1111, 0, 8'h00, 0, 8'hF0, 8'h08, 4'b1000, 0, "R6 ring rise no flag");
        cyc(4'b1011, 0, 8'h00, 0, 8'hB4, 8'h08, 4'b1000, 1, "R6 ring fall flag");
        cyc(4'b1001, 0, 8'h00, 1, 8'h92, 8'h08, 4'b1000, 1, "R8 read with new dsr change");
        cyc(4'b1001, 0, 8'h00, 1, 8'h90, 8'h08, 4'b1000, 0, "R8 read no change");
        cyc(4'b0001, 0, 8'h00, 0, 8'h18, 8'h08, 4'b1000, 1, "R5 dcd change");
        cyc(4'b0001, 0, 8'h00, 1, 8'h10, 8'h08, 4'b1000, 0, "R8 clear dcd flag");
        cyc(4'b0001, 1, 8'hE7, 0, 8'h10, 8'h07, 4'b0111, 0, "R2 R3 write low five bits");
        cyc(4'b0001, 1, 8'h1D, 0, 8'h10, 8'h1D, 4'b0000, 0, "R11 loop pins low");
        cyc(4'b0001, 0, 8'h00, 0, 8'hEB, 8'h1D, 4'b0000, 1, "R10 loop crossover");
        cyc(4'b0000, 0, 8'h00, 1, 8'hE0, 8'h1D, 4'b0000, 0, "R11 ext pins ignored");
        cyc(4'b1111, 0, 8'h00, 0, 8'hE0, 8'h1D, 4'b0000, 0, "R11 ext pins ignored high");
        cyc(4'b1111, 1, 8'h1A, 0, 8'hE0, 8'h1A, 4'b0000, 0, "R10 loop rewrite");
        cyc(4'b1111, 0, 8'h00, 0, 8'h97, 8'h1A, 4'b0000, 1, "R10 R6 loop change flags");
        cyc(4'b1111, 1, 8'h03, 0, 8'h97, 8'h03, 4'b0011, 1, "R3 loop off");
        cyc(4'b1111, 0, 8'h00, 1, 8'hF2, 8'h03, 4'b0011, 1, "R4 R8 back to ext pins");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule